// File: doc/BRIEF.md
# Programmable COM Port Address Decoder

This block sits between the ten host address lines of a PC expansion bus and an emulated UART register file. Software on the local processor writes a decode register whose two-bit port field picks one of four standard serial port bases. When host address bits 9 to 3 equal the chosen base and a host read or write strobe is active, the block raises an internal select for the register file and presents the low three address bits as the register index. A force bit in the decode register additionally drives an external active-low chip-select pin.

Decoding is disabled out of reset. It turns on only after the decode register has been written at least once and a configuration write then sets the enable bit. A configuration write made while the decode register is still unwritten is ignored. Until decoding is on, the host-facing pins stay high-impedance, which prevents bus contention if the external select line happens to be pulled low. Accesses flagged as DMA mailbox cycles never produce any select.

Top module: `com_port_decoder`

## Requirements
- R1: After reset, `hostDriveEn` is 0, `uartSel` is 0 and `extCsN` is 1, whatever the host address and strobes.
- R2: The port field is bits 4:3 of the decode register. Field 0 selects base 0x3F8, 1 selects 0x2F8, 2 selects 0x3E8 and 3 selects 0x2E8. Only an address whose bits 9:3 equal the selected base's bits 9:3 matches.
- R3: `regIdx` always equals host address bits 2:0, combinationally.
- R4: `uartSel` is 1 exactly when decoding is enabled, the address matches, at least one of `hostRdN`/`hostWrN` is low, and `mailboxSel` is 0. It follows the address and strobes in the same cycle.
- R5: `extCsN` is 0 only when bit 7 (force) of the decode register is 1 and the R4 conditions hold. With the force bit at 0, `extCsN` stays 1 even while `uartSel` is 1.
- R6: While `mailboxSel` is 1, `uartSel` is 0 and `extCsN` is 1.
- R7: A configuration write with bit 5 set, made before any decode register write since reset, has no effect: decoding stays disabled.
- R8: After the decode register has been written, a configuration write sets the decode enable to its bit 5 from the next clock edge. Bit 5 at 1 enables decoding and bit 5 at 0 disables it.
- R9: `hostDriveEn` equals the decode enable. It is 0, meaning the host pins are high-impedance, from reset until decoding is enabled.
- R10: A new decode register write retargets the match and force behaviour from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| decWr | input | 1 | Write strobe for the decode register |
| cfgWr | input | 1 | Write strobe for the configuration register |
| wrData | input | 8 | Write data for either register |
| hostAddr | input | 10 | Host address lines 9:0 |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| mailboxSel | input | 1 | Current host access targets the DMA mailbox |
| uartSel | output | 1 | Internal select for the UART register file |
| regIdx | output | 3 | Internal register index |
| extCsN | output | 1 | Forced external chip select, active low |
| hostDriveEn | output | 1 | Host pin drive enable; 0 leaves the pins high-impedance |

## Verification
The register writes take effect at the clock edge that samples their strobe, so their results are due one edge after the strobe. The bench drives each strobe on a falling edge, removes it on the following falling edge, and checks `hostDriveEn` and the decode behaviour only after that rising edge has passed. The select, index and chip-select outputs are combinational from the host address, strobes and mailbox flag. The bench therefore changes those inputs on a falling edge and samples the outputs one nanosecond later, in the same cycle, with no clock edge in between.

// File: rtl/com_dec_pkg.sv
package com_dec_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadDecode;  // capture wrData into the decode register
    logic enable;      // decoding currently enabled
  } decStrobes_t;

  // Base of port slot n: bit 0 of the slot lowers the base by 0x100 and
  // bit 1 lowers it by 0x010, starting from 0x3F8.
  function automatic logic [9:0] slotBase(input logic [1:0] slot);
    logic [9:0] b;
    b = 10'h3F8;
    if (slot[0]) b = b - 10'h100;
    if (slot[1]) b = b - 10'h010;
    return b;
  endfunction

endpackage

// File: rtl/com_dec_ctrl.sv
module com_dec_ctrl
  import com_dec_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CFG_EN_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decWr,
  input  logic              cfgWr,
  input  logic [DATA_W-1:0] wrData,
  output decStrobes_t       strobes
);

  logic decWritten;
  logic decodeOn;

  // Remembers that the decode register has been programmed since reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decWritten <= 1'b0;
    else if (decWr) decWritten <= 1'b1;
  end

  // Enable only follows a config write once the decode register is valid.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decodeOn <= 1'b0;
    else if (cfgWr && decWritten) decodeOn <= wrData[CFG_EN_BIT];
  end

  always_comb begin
    strobes.loadDecode = decWr;
    strobes.enable     = decodeOn;
  end

endmodule

// File: rtl/com_dec_dp.sv
module com_dec_dp
  import com_dec_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 10,
  parameter int IDX_W     = 3,
  parameter int NUM_PORTS = 4,
  parameter int SEL_LSB   = 3,
  parameter int FORCE_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  decStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              mailboxSel,
  output logic              uartSel,
  output logic [IDX_W-1:0]  regIdx,
  output logic              extCsN
);

  localparam int SEL_W = $clog2(NUM_PORTS);
  localparam int CMP_W = ADDR_W - IDX_W;

  logic [SEL_W-1:0]     portSel;
  logic                 forceCs;
  logic [NUM_PORTS-1:0] slotHit;
  logic                 addrMatch;
  logic                 strobeActive;
  logic                 accessOk;

  // Decode register fields.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portSel <= '0;
      forceCs <= 1'b0;
    end else if (strobes.loadDecode) begin
      portSel <= wrData[SEL_LSB +: SEL_W];
      forceCs <= wrData[FORCE_BIT];
    end
  end

  // One comparator per port slot; the selected slot's result is used.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : gSlot
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(slotBase(2'(g)));
    assign slotHit[g] = (hostAddr[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);
  end

  always_comb begin
    addrMatch    = slotHit[portSel];
    strobeActive = !hostRdN || !hostWrN;
    accessOk     = strobes.enable && addrMatch && strobeActive && !mailboxSel;
    uartSel      = accessOk;
    extCsN       = !(accessOk && forceCs);
    regIdx       = hostAddr[IDX_W-1:0];
  end

endmodule

// File: rtl/com_port_decoder.sv
module com_port_decoder
  import com_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       decWr,
  input  logic       cfgWr,
  input  logic [7:0] wrData,
  input  logic [9:0] hostAddr,
  input  logic       hostRdN,
  input  logic       hostWrN,
  input  logic       mailboxSel,
  output logic       uartSel,
  output logic [2:0] regIdx,
  output logic       extCsN,
  output logic       hostDriveEn
);

  decStrobes_t strobes;

  com_dec_ctrl #(.DATA_W(8), .CFG_EN_BIT(5)) uCtrl (
    .clk(clk), .rstN(rstN), .decWr(decWr), .cfgWr(cfgWr),
    .wrData(wrData), .strobes(strobes)
  );

  com_dec_dp #(
    .DATA_W(8), .ADDR_W(10), .IDX_W(3), .NUM_PORTS(4),
    .SEL_LSB(3), .FORCE_BIT(7)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .hostAddr(hostAddr), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .mailboxSel(mailboxSel), .uartSel(uartSel), .regIdx(regIdx),
    .extCsN(extCsN)
  );

  assign hostDriveEn = strobes.enable;

endmodule

// File: rtl/com_port_decoder_chk.sv
module com_port_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       decWr,
  input logic       cfgWr,
  input logic [7:0] wrData,
  input logic       hostRdN,
  input logic       hostWrN,
  input logic       mailboxSel,
  input logic       uartSel,
  input logic       extCsN,
  input logic       hostDriveEn
);

  logic seenDec;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenDec <= 1'b0;
    else if (decWr) seenDec <= 1'b1;
  end

  AST_NO_SEL_MAILBOX: assert property (@(posedge clk) disable iff (!rstN)
    mailboxSel |-> (!uartSel && extCsN));  // R6

  AST_SEL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !hostDriveEn |-> (!uartSel && extCsN));  // R9

  AST_CS_IMPLIES_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !extCsN |-> uartSel);  // R5

  AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    uartSel |-> (!hostRdN || !hostWrN));  // R4

  AST_CFG_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !seenDec && !hostDriveEn) |=> !hostDriveEn);  // R7

  AST_ENABLE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && seenDec) |=> (hostDriveEn == $past(wrData[5])));  // R8

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> $stable(hostDriveEn));  // R8

endmodule

bind com_port_decoder com_port_decoder_chk uChk (
  .clk(clk), .rstN(rstN), .decWr(decWr), .cfgWr(cfgWr), .wrData(wrData),
  .hostRdN(hostRdN), .hostWrN(hostWrN), .mailboxSel(mailboxSel),
  .uartSel(uartSel), .extCsN(extCsN), .hostDriveEn(hostDriveEn)
);

// File: tb/sim_com_port_decoder.sv
`timescale 1ns/1ps
module sim_com_port_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decWr = 1'b0;
  logic       cfgWr = 1'b0;
  logic [7:0] wrData = '0;
  logic [9:0] hostAddr = '0;
  logic       hostRdN = 1'b1;
  logic       hostWrN = 1'b1;
  logic       mailboxSel = 1'b0;
  logic       uartSel;
  logic [2:0] regIdx;
  logic       extCsN;
  logic       hostDriveEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  com_port_decoder u0 (
    .clk(clk), .rstN(rstN), .decWr(decWr), .cfgWr(cfgWr), .wrData(wrData),
    .hostAddr(hostAddr), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .mailboxSel(mailboxSel), .uartSel(uartSel), .regIdx(regIdx),
    .extCsN(extCsN), .hostDriveEn(hostDriveEn)
  );

  function automatic logic [9:0] expBase(input int slot);
    case (slot)
      0: return 10'h3F8;
      1: return 10'h2F8;
      2: return 10'h3E8;
      default: return 10'h2E8;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeDec(input logic [7:0] v);
    @(negedge clk); decWr = 1'b1; wrData = v;
    @(negedge clk); decWr = 1'b0; wrData = '0;
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWr = 1'b1; wrData = v;
    @(negedge clk); cfgWr = 1'b0; wrData = '0;
  endtask

  task automatic access(input logic [9:0] a, input logic rdN, input logic wrN, input logic mb);
    @(negedge clk);
    hostAddr = a; hostRdN = rdN; hostWrN = wrN; mailboxSel = mb;
    #1;
  endtask

  task automatic idle();
    @(negedge clk); hostRdN = 1'b1; hostWrN = 1'b1; mailboxSel = 1'b0;
  endtask

  task automatic tReset();
    access(10'h3F8, 1'b0, 1'b1, 1'b0);
    check("R1", "hostDriveEn", hostDriveEn, 0);
    check("R1", "uartSel", uartSel, 0);
    check("R1", "extCsN", extCsN, 1);
    idle();
  endtask

  task automatic tOrder();
    writeCfg(8'h20);
    check("R7", "hostDriveEn after early cfg", hostDriveEn, 0);
    access(10'h3F8, 1'b0, 1'b1, 1'b0);
    check("R7", "uartSel after early cfg", uartSel, 0);
    idle();
    writeDec(8'h80);
    check("R9", "hostDriveEn before enable", hostDriveEn, 0);
    writeCfg(8'h20);
    check("R8", "hostDriveEn after enable", hostDriveEn, 1);
    check("R9", "pins driven", hostDriveEn, 1);
  endtask

  task automatic tPorts();
    for (int s = 0; s < 4; s++) begin
      writeDec(8'h80 | 8'(s << 3));
      for (int i = 0; i < 8; i += 3) begin
        access(expBase(s) + 10'(i), 1'b0, 1'b1, 1'b0);
        check("R2", $sformatf("uartSel slot %0d", s), uartSel, 1);
        check("R5", "extCsN forced", extCsN, 0);
        check("R3", "regIdx", regIdx, i);
      end
      access(expBase((s + 1) % 4), 1'b0, 1'b1, 1'b0);
      check("R2", "other base rejected", uartSel, 0);
      check("R10", "extCsN on other base", extCsN, 1);
      access(expBase(s) + 10'h008, 1'b0, 1'b1, 1'b0);
      check("R2", "adjacent range rejected", uartSel, 0);
      idle();
    end
  endtask

  task automatic tStrobes();
    writeDec(8'h80 | 8'(1 << 3));
    access(10'h2FB, 1'b1, 1'b1, 1'b0);
    check("R4", "no strobe", uartSel, 0);
    check("R4", "regIdx without strobe", regIdx, 3);
    access(10'h2FB, 1'b1, 1'b0, 1'b0);
    check("R4", "write strobe", uartSel, 1);
    access(10'h2FB, 1'b0, 1'b0, 1'b1);
    check("R6", "mailbox uartSel", uartSel, 0);
    check("R6", "mailbox extCsN", extCsN, 1);
    idle();
  endtask

  task automatic tForce();
    writeDec(8'h00);
    access(10'h3F9, 1'b0, 1'b1, 1'b0);
    check("R5", "uartSel without force", uartSel, 1);
    check("R5", "extCsN without force", extCsN, 1);
    check("R10", "retargeted to slot 0", uartSel, 1);
    idle();
  endtask

  task automatic tDisable();
    writeCfg(8'h00);
    check("R8", "hostDriveEn after disable", hostDriveEn, 0);
    access(10'h3F9, 1'b0, 1'b1, 1'b0);
    check("R8", "uartSel after disable", uartSel, 0);
    idle();
    writeCfg(8'h20);
    check("R8", "re-enable", hostDriveEn, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tReset();
    tOrder();
    tPorts();
    tStrobes();
    tForce();
    tDisable();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule